// File: doc/BRIEF.md
# Periodic Time-Base and RTC Interrupt Unit

This unit produces two periodic interrupt sources from a single input clock. A free-running binary counter advances on every cycle of that clock. Each source picks one tap of the counter, and a rising transition on that tap is a timeout. The time-base period is fixed when the unit is built, by the parameter `TB_SEL`. The RTC period comes from a 3-bit rate field that software may rewrite at any time. Changing that field does not restart the counter.

Each timeout sets a pending flag for its own source and also sets a shared multi-function pending flag. Hardware never clears the per-source flags; software clears them with clear strobes. The shared flag is cleared by an interrupt acknowledge or by its own clear strobe.

A request to the fixed vector goes out under three conditions:
- the master multi-function enable is set and the shared flag is pending;
- at least one source has both its enable and its pending flag set;
- the call stack is not full.

Top module: `periodic_irq_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tb_pend`, `rtc_pend`, `mf_pend` and `irq_req` are 0 and `irq_vec` is 0.
- R2: The shared counter starts at 0 after reset and increments once per clock. A time-base timeout occurs in the cycle in which the count modulo P equals P/2, where P = 2^(12+TB_SEL) and TB_SEL is 0..3. `tb_pend` becomes 1 in the following cycle.
- R3: An RTC timeout occurs in the cycle in which the count modulo Q equals Q/2, where Q = 2^(8+rtc_rate) and `rtc_rate` is 0..7 (rate 0 gives 256 cycles, rate 7 gives 32768). `rtc_pend` becomes 1 in the following cycle.
- R4: Any timeout of either source sets `mf_pend` in the same cycle as the source's own flag. This happens whatever the enables and `stack_full` are.
- R5: `tb_pend` and `rtc_pend` stay at 1 until their own clear strobe (`tb_clr`, `rtc_clr`) is high at a clock edge. A clear strobe or `irq_ack` has no effect on any other flag.
- R6: If a timeout and the clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R7: `mf_pend` is cleared by `irq_ack` or by `mf_clr`, unless a timeout occurs in that same cycle.
- R8: `irq_req` equals `mf_en & mf_pend & ~stack_full & ((tb_en & tb_pend) | (rtc_en & rtc_pend))`, combinationally from the current flags and inputs.
- R9: `irq_vec` is 8'h18 while `irq_req` is 1 and 0 otherwise.
- R10: A new `rtc_rate` value applies from the next counter tap match without resetting the counter, so the next RTC timeout follows the R3 rule with the new rate on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock fS; the shared counter advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rtc_rate | input | 3 | RTC period select, period 2^(8+rtc_rate) cycles |
| mf_en | input | 1 | Master multi-function interrupt enable |
| tb_en | input | 1 | Time-base interrupt enable |
| rtc_en | input | 1 | RTC interrupt enable |
| stack_full | input | 1 | High when the call stack cannot take another entry |
| tb_clr | input | 1 | Clear strobe for the time-base pending flag |
| rtc_clr | input | 1 | Clear strobe for the RTC pending flag |
| mf_clr | input | 1 | Clear strobe for the shared pending flag |
| irq_ack | input | 1 | Interrupt acknowledge; clears the shared pending flag |
| tb_pend | output | 1 | Time-base pending flag |
| rtc_pend | output | 1 | RTC pending flag |
| mf_pend | output | 1 | Shared multi-function pending flag |
| irq_req | output | 1 | Request for a call to the fixed vector |
| irq_vec | output | 8 | Vector address, 8'h18 while requesting |

## Verification
A wrong counter value moves every later timeout. The error shows up as a pending flag rising in the wrong cycle, at the latest one full period of the slower selected tap after the fault. A flag that is lost or stuck shows up in the next cycle, either on its own output or through `irq_req` and `irq_vec`. The bench therefore compares every output in every cycle against a cycle-accurate reference built from the requirements. This catches a one-cycle shift in a timeout or a wrongly prioritised clear at the cycle where it happens.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    localparam int CNT_W    = 15;
    localparam int TB_BASE  = 12;
    localparam int RTC_BASE = 8;
    localparam int RATE_W   = 3;
    localparam int EXP_W    = 4;

    typedef struct packed {
        logic tb;
        logic rtc;
    } tick_s;

    typedef enum logic [1:0] {
        FLG_TB  = 2'd0,
        FLG_RTC = 2'd1,
        FLG_MF  = 2'd2
    } flag_idx_e;

    localparam logic [CNT_W:0] ONE_W = {{CNT_W{1'b0}}, 1'b1};

    // True when the low 'k' bits of the count equal 2^(k-1): the tap just rose.
    function automatic logic tap_hit(input logic [CNT_W-1:0] c, input logic [EXP_W-1:0] k);
        logic [CNT_W:0] span;
        span    = ONE_W << k;
        tap_hit = (({1'b0, c} & (span - ONE_W)) == (span >> 1));
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider
    import tick_irq_pkg::*;
#(
    parameter int TB_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output tick_s             tick
);

    localparam logic [EXP_W-1:0] TB_EXP = EXP_W'(TB_BASE + TB_SEL);

    logic [CNT_W-1:0] count_q;
    logic [EXP_W-1:0] rtc_exp;

    assign rtc_exp = EXP_W'(RTC_BASE) + EXP_W'(rate);

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + 1'b1;
    end

    always_comb begin
        tick.tb  = tap_hit(count_q, TB_EXP);
        tick.rtc = tap_hit(count_q, rtc_exp);
    end

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int          VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_ADDR = 8'h18
) (
    input  logic             mf_en,
    input  logic             tb_en,
    input  logic             rtc_en,
    input  logic             stack_full,
    input  logic             tb_pend,
    input  logic             rtc_pend,
    input  logic             mf_pend,
    output logic             req,
    output logic [VEC_W-1:0] vec
);

    logic any_src;

    always_comb begin
        any_src = (tb_en & tb_pend) | (rtc_en & rtc_pend);
        req     = mf_en & mf_pend & any_src & ~stack_full;
        vec     = req ? VEC_ADDR : '0;
    end

endmodule

// File: rtl/periodic_irq_unit.sv
module periodic_irq_unit
    import tick_irq_pkg::*;
#(
    parameter int               TB_SEL   = 0,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_ADDR = 8'h18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       rtc_rate,
    input  logic             mf_en,
    input  logic             tb_en,
    input  logic             rtc_en,
    input  logic             stack_full,
    input  logic             tb_clr,
    input  logic             rtc_clr,
    input  logic             mf_clr,
    input  logic             irq_ack,
    output logic             tb_pend,
    output logic             rtc_pend,
    output logic             mf_pend,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);

    localparam int NFLG = 3;

    tick_s           tick;
    logic [NFLG-1:0] flg_set;
    logic [NFLG-1:0] flg_clr;
    logic [NFLG-1:0] flg_q;

    tick_divider #(.TB_SEL(TB_SEL)) u_div (
        .clk  (clk),
        .rst  (rst),
        .rate (rtc_rate),
        .tick (tick)
    );

    always_comb begin
        flg_set          = '0;
        flg_clr          = '0;
        flg_set[FLG_TB]  = tick.tb;
        flg_set[FLG_RTC] = tick.rtc;
        flg_set[FLG_MF]  = tick.tb | tick.rtc;
        flg_clr[FLG_TB]  = tb_clr;
        flg_clr[FLG_RTC] = rtc_clr;
        flg_clr[FLG_MF]  = mf_clr | irq_ack;
    end

    for (genvar i = 0; i < NFLG; i++) begin : g_flag
        sticky_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (flg_set[i]),
            .clr (flg_clr[i]),
            .q   (flg_q[i])
        );
    end

    assign tb_pend  = flg_q[FLG_TB];
    assign rtc_pend = flg_q[FLG_RTC];
    assign mf_pend  = flg_q[FLG_MF];

    irq_gate #(.VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_gate (
        .mf_en      (mf_en),
        .tb_en      (tb_en),
        .rtc_en     (rtc_en),
        .stack_full (stack_full),
        .tb_pend    (tb_pend),
        .rtc_pend   (rtc_pend),
        .mf_pend    (mf_pend),
        .req        (irq_req),
        .vec        (irq_vec)
    );

endmodule

// File: rtl/periodic_irq_chk.sv
module periodic_irq_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stack_full,
    input logic             tb_clr,
    input logic             rtc_clr,
    input logic             mf_clr,
    input logic             irq_ack,
    input logic             tb_pend,
    input logic             rtc_pend,
    input logic             mf_pend,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!tb_pend && !rtc_pend && !mf_pend && !irq_req));

    // R4
    tb_sets_mf_chk: assert property (@(posedge clk) disable iff (rst)
        (!tb_pend ##1 tb_pend) |-> mf_pend);

    // R4
    rtc_sets_mf_chk: assert property (@(posedge clk) disable iff (rst)
        (!rtc_pend ##1 rtc_pend) |-> mf_pend);

    // R5
    tb_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tb_pend && !tb_clr) |=> tb_pend);

    // R5
    rtc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rtc_pend && !rtc_clr) |=> rtc_pend);

    // R7
    mf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mf_pend && !mf_clr && !irq_ack) |=> mf_pend);

    // R8
    stack_block_chk: assert property (@(posedge clk) disable iff (rst)
        stack_full |-> !irq_req);

    // R9
    vec_value_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec == VEC_W'(8'h18)));

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_vec == '0));

endmodule

bind periodic_irq_unit periodic_irq_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stack_full (stack_full),
    .tb_clr     (tb_clr),
    .rtc_clr    (rtc_clr),
    .mf_clr     (mf_clr),
    .irq_ack    (irq_ack),
    .tb_pend    (tb_pend),
    .rtc_pend   (rtc_pend),
    .mf_pend    (mf_pend),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec)
);

// File: tb/sim_periodic_irq_unit.sv
`timescale 1ns/1ps
module sim_periodic_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int TB_SEL     = 0;
    localparam int MAX_CYC    = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] rtc_rate = 3'd0;
    logic       mf_en = 1'b0, tb_en = 1'b0, rtc_en = 1'b0, stack_full = 1'b0;
    logic       tb_clr = 1'b0, rtc_clr = 1'b0, mf_clr = 1'b0, irq_ack = 1'b0;
    logic       tb_pend, rtc_pend, mf_pend, irq_req;
    logic [7:0] irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [14:0] m_cnt;
    logic        m_tb, m_rtc, m_mf;

    periodic_irq_unit #(.TB_SEL(TB_SEL)) u0 (
        .clk(clk), .rst(rst), .rtc_rate(rtc_rate),
        .mf_en(mf_en), .tb_en(tb_en), .rtc_en(rtc_en), .stack_full(stack_full),
        .tb_clr(tb_clr), .rtc_clr(rtc_clr), .mf_clr(mf_clr), .irq_ack(irq_ack),
        .tb_pend(tb_pend), .rtc_pend(rtc_pend), .mf_pend(mf_pend),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Timeout rule from R2/R3: count mod 2^k equals 2^(k-1).
    function automatic bit timeout_at(input logic [14:0] c, input int k);
        int unsigned p;
        p = 32'd1 << k;
        return ((int'(c) % p) == (p / 2));
    endfunction

    function automatic bit exp_req();
        return mf_en & m_mf & ~stack_full & ((tb_en & m_tb) | (rtc_en & m_rtc));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at t=%0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2/R6 tb_pend",  {7'd0, tb_pend},  {7'd0, m_tb});
        chk("R3/R10 rtc_pend", {7'd0, rtc_pend}, {7'd0, m_rtc});
        chk("R4/R7 mf_pend",  {7'd0, mf_pend},  {7'd0, m_mf});
        chk("R8 irq_req",     {7'd0, irq_req},  {7'd0, exp_req()});
        chk("R9 irq_vec",     irq_vec,          exp_req() ? 8'h18 : 8'h00);
    endtask

    // One cycle: drive inputs already set, advance model and design by one edge.
    task automatic step();
        bit th, rh;
        th = timeout_at(m_cnt, 12 + TB_SEL);
        rh = timeout_at(m_cnt, 8 + int'(rtc_rate));
        @(posedge clk);
        m_tb  = th | (m_tb  & ~tb_clr);
        m_rtc = rh | (m_rtc & ~rtc_clr);
        m_mf  = th | rh | (m_mf & ~(mf_clr | irq_ack));
        m_cnt = m_cnt + 15'd1;
        @(negedge clk);
        check_all();
    endtask

    task automatic rand_inputs(input int clr_odds);
        mf_en      = ($urandom % 4) != 0;
        tb_en      = ($urandom % 4) != 0;
        rtc_en     = ($urandom % 4) != 0;
        stack_full = ($urandom % 5) == 0;
        tb_clr     = ($urandom % clr_odds) == 0;
        rtc_clr    = ($urandom % clr_odds) == 0;
        mf_clr     = ($urandom % clr_odds) == 0;
        irq_ack    = ($urandom % clr_odds) == 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_cnt = '0; m_tb = 1'b0; m_rtc = 1'b0; m_mf = 1'b0;
        mf_en = 1'b1; tb_en = 1'b1; rtc_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with all enables up
        chk("R1 tb_pend",  {7'd0, tb_pend},  8'd0);
        chk("R1 rtc_pend", {7'd0, rtc_pend}, 8'd0);
        chk("R1 mf_pend",  {7'd0, mf_pend},  8'd0);
        chk("R1 irq_req",  {7'd0, irq_req},  8'd0);
        chk("R1 irq_vec",  irq_vec,          8'd0);
        rst = 1'b0;

        // Directed: rate 0, no clears; first RTC flag after 129 edges (R3, R4)
        rtc_rate = 3'd0;
        for (int i = 0; i < 3000; i++) step();

        // Directed R6: clears held high, timeouts must still leave flags set
        tb_clr = 1'b1; rtc_clr = 1'b1; mf_clr = 1'b1; irq_ack = 1'b1;
        for (int i = 0; i < 9000; i++) step();
        tb_clr = 1'b0; rtc_clr = 1'b0; mf_clr = 1'b0; irq_ack = 1'b0;

        // Directed R8: stack full blocks a pending request
        stack_full = 1'b1;
        for (int i = 0; i < 300; i++) step();
        stack_full = 1'b0;

        // Random phase with rate changes mid-count (R5, R7, R10)
        for (int i = 0; i < 100000; i++) begin
            if (($urandom % 3000) == 0) rtc_rate = 3'($urandom % 8);
            rand_inputs((i % 20000) < 10000 ? 64 : 4);
            step();
        end

        // Long hold at the slowest rate (R3 rate 7)
        rtc_rate = 3'd7;
        tb_clr = 1'b0; rtc_clr = 1'b1; mf_clr = 1'b0; irq_ack = 1'b0;
        step();
        rtc_clr = 1'b0;
        for (int i = 0; i < 34000; i++) step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule